// File: doc/BRIEF.md
# Snoop-Aware Bus Hold Arbiter

This block sits on the system side of a processor whose cache keeps dirty lines. An outside bus master asks for one access. The block first takes the processor off the bus by raising a hold request. Once the acknowledge has settled, it strobes a snoop that carries the direction of the access, then waits a fixed latency for the processor's modified-line hit flag.

If the snooped line is clean, the master is granted the bus. The hold request stays up until the master reports that it is done.

If the line is dirty, the block drops the hold request and pushes the master off the bus in the same clock. The processor then writes the line back in a burst. One clock after the processor's first write-back address strobe, the hold request comes back. When the processor acknowledges again, the back-off is lifted and the master may retry. The master's retry strobe snoops the line again in that same clock.

The request and grant pair behaves like a valid/ready handshake. `mst_req` and `mst_wr` must stay steady from the request until `mst_done`. `mst_gnt` is the ready side, and the master may not drive its bus while the grant is low. Holding the request low is the master's only form of back-pressure. All other pins are plain control levels.

Top module: `snoop_hold_arb`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `cpu_hold_req`, `snoop_strobe`, `mst_backoff` and `mst_gnt` all low.
- R2: A request seen in idle raises `cpu_hold_req` in the following cycle.
- R3: `snoop_strobe` is high for exactly one cycle. It rises only after `hold_ack` has been high for ACK_MIN (default 1) full cycles, and never in the cycle where the acknowledge first appears.
- R4: During a snoop strobe, `snoop_wr` is 1 for a write access (`mst_wr`=1) and 0 for a read.
- R5: `dirty_hit` (1 = modified line) is sampled only in the cycle HIT_LAT (default 2) cycles after the strobe. Its value in any other cycle has no effect on the outputs.
- R6: On a clean snoop, `mst_gnt` rises the next cycle with `cpu_hold_req` still high and `mst_backoff` low. Both grant and hold then stay up until the cycle after `mst_done`, when both fall.
- R7: On a dirty snoop, `cpu_hold_req` falls and `mst_backoff` rises in the same cycle, which is the cycle right after the sample.
- R8: After a dirty snoop, `cpu_hold_req` stays low until `cpu_strobe` is seen. It returns exactly one cycle later, with `mst_backoff` still high, and it is high at the burst's final ready (`cpu_rdy` and `cpu_last` both high).
- R9: In the write-back phase, the first cycle with `hold_ack` high is followed by a cycle with `mst_backoff` low, `mst_gnt` high and `cpu_hold_req` high.
- R10: In that retry phase, `mst_strobe` produces `snoop_strobe` in the same cycle, with `snoop_wr` following `mst_wr`. A new snoop is then sampled HIT_LAT cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mst_req | input | 1 | Master wants one access (valid) |
| mst_wr | input | 1 | Direction of the access, 1 = write |
| mst_strobe | input | 1 | Master address strobe on its retry |
| mst_done | input | 1 | Master has finished its access |
| hold_ack | input | 1 | Processor has released the bus |
| dirty_hit | input | 1 | Snoop hit a modified line, 1 = hit |
| cpu_strobe | input | 1 | Processor address strobe |
| cpu_last | input | 1 | Processor marks the last transfer of a burst |
| cpu_rdy | input | 1 | Transfer ready from memory |
| cpu_hold_req | output | 1 | Hold request to the processor |
| snoop_strobe | output | 1 | Snoop address strobe to the processor |
| snoop_wr | output | 1 | Snoop invalidate flag, 1 for a write |
| mst_backoff | output | 1 | Forces the master off the bus |
| mst_gnt | output | 1 | Master may use the bus (ready) |

## Verification
The assertions assume three things about the processor model. It keeps `hold_ack` high for as long as the hold request is up. It gives its write-back strobe only after being pushed off the bus. It gives its final ready at or after the cycle following that strobe. They also assume the master keeps `mst_wr` steady for the whole access.

The bench's processor model follows these rules by construction. Its random choices are limited to the acknowledge delay, the gap before the write-back, the burst length, the retry delay and the grant length. Every burst starts its first ready in the cycle the hold request returns. Outside the sampling cycle, `dirty_hit` is filled with random values, so that ignoring it is actually tested.

// File: rtl/sha_pkg.sv
package sha_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_REQ,
    S_SNOOP,
    S_WAIT,
    S_GRANT,
    S_BACKOFF,
    S_WB,
    S_RETRY
  } sha_state_e;
endpackage

// File: rtl/sha_tick_cnt.sv
module sha_tick_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (en)    count <= count + 1'b1;
  end
endmodule

// File: rtl/sha_ctrl.sv
module sha_ctrl
  import sha_pkg::*;
#(
  parameter int ACK_MIN = 1,
  parameter int HIT_LAT = 2,
  localparam int AW = $clog2(ACK_MIN + 1),
  localparam int LW = $clog2(HIT_LAT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mst_req,
  input  logic         mst_strobe,
  input  logic         mst_done,
  input  logic         hold_ack,
  input  logic         dirty_hit,
  input  logic         cpu_strobe,
  input  logic [AW-1:0] ack_cnt,
  input  logic [LW-1:0] lat_cnt,
  output sha_state_e   state
);
  sha_state_e nxt;
  logic ack_done, lat_done;

  assign ack_done = hold_ack && (ack_cnt == AW'(ACK_MIN - 1));
  assign lat_done = (lat_cnt == LW'(HIT_LAT - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (mst_req)    nxt = S_REQ;
      S_REQ:     if (ack_done)   nxt = S_SNOOP;
      S_SNOOP:                   nxt = S_WAIT;
      S_WAIT:    if (lat_done)   nxt = dirty_hit ? S_BACKOFF : S_GRANT;
      S_GRANT:   if (mst_done)   nxt = S_IDLE;
      S_BACKOFF: if (cpu_strobe) nxt = S_WB;
      S_WB:      if (hold_ack)   nxt = S_RETRY;
      S_RETRY:   if (mst_strobe) nxt = S_WAIT;
      default:                   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  // R5: the hit flag decides the path only at the sampling cycle
  a_r5_sample_point: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !lat_done) |=> (state == S_WAIT));
endmodule

// File: rtl/sha_drive.sv
module sha_drive
  import sha_pkg::*;
(
  input  sha_state_e state,
  input  logic       mst_strobe,
  input  logic       wr_q,
  output logic       cpu_hold_req,
  output logic       snoop_strobe,
  output logic       snoop_wr,
  output logic       mst_backoff,
  output logic       mst_gnt
);
  always_comb begin
    cpu_hold_req = state inside {S_REQ, S_SNOOP, S_WAIT, S_GRANT, S_WB, S_RETRY};
    snoop_strobe = (state == S_SNOOP) || (state == S_RETRY && mst_strobe);
    snoop_wr     = snoop_strobe && wr_q;
    mst_backoff  = state inside {S_BACKOFF, S_WB};
    mst_gnt      = state inside {S_RETRY, S_GRANT};
  end
endmodule

// File: rtl/snoop_hold_arb.sv
module snoop_hold_arb
  import sha_pkg::*;
#(
  parameter int ACK_MIN = 1,
  parameter int HIT_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mst_req,
  input  logic mst_wr,
  input  logic mst_strobe,
  input  logic mst_done,
  input  logic hold_ack,
  input  logic dirty_hit,
  input  logic cpu_strobe,
  input  logic cpu_last,
  input  logic cpu_rdy,
  output logic cpu_hold_req,
  output logic snoop_strobe,
  output logic snoop_wr,
  output logic mst_backoff,
  output logic mst_gnt
);
  localparam int AW = $clog2(ACK_MIN + 1);
  localparam int LW = $clog2(HIT_LAT + 1);

  sha_state_e    state;
  logic [AW-1:0] ack_cnt;
  logic [LW-1:0] lat_cnt;
  logic          wr_q, ack_en, lat_en;

  assign ack_en = (state == S_REQ) && hold_ack;
  assign lat_en = (state == S_WAIT);

  always_ff @(posedge clk) begin
    if (rst)                             wr_q <= 1'b0;
    else if (state == S_IDLE && mst_req) wr_q <= mst_wr;
  end

  sha_tick_cnt #(.W(AW)) u_ack_cnt (
    .clk(clk), .rst(rst), .clr(!ack_en), .en(ack_en), .count(ack_cnt));

  sha_tick_cnt #(.W(LW)) u_lat_cnt (
    .clk(clk), .rst(rst), .clr(!lat_en), .en(lat_en), .count(lat_cnt));

  sha_ctrl #(.ACK_MIN(ACK_MIN), .HIT_LAT(HIT_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .mst_req(mst_req), .mst_strobe(mst_strobe),
    .mst_done(mst_done), .hold_ack(hold_ack), .dirty_hit(dirty_hit),
    .cpu_strobe(cpu_strobe), .ack_cnt(ack_cnt), .lat_cnt(lat_cnt),
    .state(state));

  sha_drive u_drive (
    .state(state), .mst_strobe(mst_strobe), .wr_q(wr_q),
    .cpu_hold_req(cpu_hold_req), .snoop_strobe(snoop_strobe),
    .snoop_wr(snoop_wr), .mst_backoff(mst_backoff), .mst_gnt(mst_gnt));

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cpu_hold_req && !snoop_strobe && !mst_backoff && !mst_gnt));

  a_r3_strobe_after_ack: assert property (@(posedge clk) disable iff (rst)
    snoop_strobe |-> (hold_ack && $past(hold_ack)));

  a_r4_dir_matches: assert property (@(posedge clk) disable iff (rst)
    snoop_strobe |-> (snoop_wr == mst_wr));

  a_r6_grant_excl: assert property (@(posedge clk) disable iff (rst)
    !(mst_gnt && mst_backoff));

  a_r7_drop_with_backoff: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_hold_req) && !$past(mst_gnt)) |-> mst_backoff);

  a_r8_rehold_after_strobe: assert property (@(posedge clk) disable iff (rst)
    (mst_backoff && !cpu_hold_req && cpu_strobe) |=> (cpu_hold_req && mst_backoff));

  a_r8_hold_by_last_rdy: assert property (@(posedge clk) disable iff (rst)
    (mst_backoff && cpu_rdy && cpu_last) |-> cpu_hold_req);

  a_r9_release_on_ack: assert property (@(posedge clk) disable iff (rst)
    (mst_backoff && cpu_hold_req && hold_ack) |=> (!mst_backoff && mst_gnt));
endmodule

// File: tb/test_snoop_hold_arb.sv
`timescale 1ns/1ps
module test_snoop_hold_arb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mst_req = 0, mst_wr = 0, mst_strobe = 0, mst_done = 0;
  logic hold_ack = 0, dirty_hit = 0, cpu_strobe = 0, cpu_last = 0, cpu_rdy = 0;
  logic cpu_hold_req, snoop_strobe, snoop_wr, mst_backoff, mst_gnt;
  int   checks = 0, fails = 0;
  bit   fin = 0;

  always #4 clk = ~clk;

  snoop_hold_arb i_snoop_hold_arb (
    .clk(clk), .rst(rst), .mst_req(mst_req), .mst_wr(mst_wr),
    .mst_strobe(mst_strobe), .mst_done(mst_done), .hold_ack(hold_ack),
    .dirty_hit(dirty_hit), .cpu_strobe(cpu_strobe), .cpu_last(cpu_last),
    .cpu_rdy(cpu_rdy), .cpu_hold_req(cpu_hold_req), .snoop_strobe(snoop_strobe),
    .snoop_wr(snoop_wr), .mst_backoff(mst_backoff), .mst_gnt(mst_gnt));

  function automatic bit junk();
    return 1'($urandom_range(1, 0));
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance to next cycle: inputs settle at negedge, outputs sampled 1 ns later
  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic finish_grant(input int hold_g);
    for (int i = 0; i < hold_g; i++) begin
      dirty_hit = junk();
      settle();
      chk("R6 grant held", mst_gnt, 1'b1);
      chk("R6 hold held", cpu_hold_req, 1'b1);
      nxt();
    end
    mst_done = 1; mst_req = 0;
    settle();
    chk("R6 grant at done", mst_gnt, 1'b1);
    nxt();
    mst_done = 0; hold_ack = 0;
    settle();
    chk("R6 hold released", cpu_hold_req, 1'b0);
    chk("R6 grant released", mst_gnt, 1'b0);
  endtask

  task automatic access(input bit wr, input bit dirty, input int ack_dly,
                        input int gap, input int beats, input int rdly,
                        input int hold_g, input int ack2);
    nxt();
    mst_req = 1; mst_wr = wr; hold_ack = 0; dirty_hit = junk();
    settle();
    chk("R2 idle hold low", cpu_hold_req, 1'b0);
    nxt();
    settle();
    chk("R2 hold raised", cpu_hold_req, 1'b1);
    for (int i = 0; i < ack_dly; i++) begin
      chk("R3 no strobe before ack", snoop_strobe, 1'b0);
      nxt(); settle();
    end
    hold_ack = 1;
    settle();
    chk("R3 no strobe in ack cycle", snoop_strobe, 1'b0);
    nxt(); settle();
    chk("R3 strobe", snoop_strobe, 1'b1);
    chk("R4 direction", snoop_wr, wr);
    nxt();
    dirty_hit = ~dirty;
    settle();
    chk("R3 strobe one cycle", snoop_strobe, 1'b0);
    nxt();
    dirty_hit = dirty;
    settle();
    nxt();
    dirty_hit = junk();
    settle();
    if (!dirty) begin
      chk("R5 clean path grant", mst_gnt, 1'b1);
      chk("R6 hold kept", cpu_hold_req, 1'b1);
      chk("R6 no backoff", mst_backoff, 1'b0);
      finish_grant(hold_g);
      return;
    end
    chk("R7 hold dropped", cpu_hold_req, 1'b0);
    chk("R7 backoff", mst_backoff, 1'b1);
    chk("R5 dirty no grant", mst_gnt, 1'b0);
    hold_ack = 0;
    for (int i = 0; i < gap; i++) begin
      nxt(); dirty_hit = junk(); settle();
      chk("R8 hold stays low", cpu_hold_req, 1'b0);
      chk("R8 backoff kept", mst_backoff, 1'b1);
    end
    nxt();
    cpu_strobe = 1;
    settle();
    chk("R8 low at strobe", cpu_hold_req, 1'b0);
    for (int b = 0; b < beats; b++) begin
      nxt();
      cpu_strobe = 0; cpu_rdy = 1; cpu_last = (b == beats - 1);
      settle();
      chk("R8 hold back in burst", cpu_hold_req, 1'b1);
      chk("R8 backoff in burst", mst_backoff, 1'b1);
    end
    for (int i = 0; i < ack2; i++) begin
      nxt();
      cpu_rdy = 0; cpu_last = 0;
      settle();
      chk("R9 backoff until ack", mst_backoff, 1'b1);
    end
    nxt();
    cpu_rdy = 0; cpu_last = 0; hold_ack = 1;
    settle();
    chk("R9 backoff in ack cycle", mst_backoff, 1'b1);
    nxt(); settle();
    chk("R9 backoff lifted", mst_backoff, 1'b0);
    chk("R9 retry grant", mst_gnt, 1'b1);
    chk("R9 hold on", cpu_hold_req, 1'b1);
    for (int i = 0; i < rdly; i++) begin
      chk("R10 no strobe before retry", snoop_strobe, 1'b0);
      nxt(); settle();
    end
    mst_strobe = 1;
    settle();
    chk("R10 retry strobe", snoop_strobe, 1'b1);
    chk("R10 retry direction", snoop_wr, wr);
    nxt();
    mst_strobe = 0; dirty_hit = junk();
    settle();
    chk("R10 strobe one cycle", snoop_strobe, 1'b0);
    nxt();
    dirty_hit = 0;
    settle();
    nxt();
    dirty_hit = junk();
    settle();
    chk("R10 resnoop clean grant", mst_gnt, 1'b1);
    finish_grant(hold_g);
  endtask

  initial begin
    #(8 * 200000);
    if (!fin) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    settle();
    chk("R1 reset hold", cpu_hold_req, 1'b0);
    chk("R1 reset backoff", mst_backoff, 1'b0);
    chk("R1 reset grant", mst_gnt, 1'b0);
    chk("R1 reset strobe", snoop_strobe, 1'b0);
    nxt();
    rst = 0;
    // directed corners: fastest paths, then long waits
    access(1'b0, 1'b0, 0, 0, 1, 0, 0, 0);
    access(1'b1, 1'b1, 0, 0, 1, 0, 0, 0);
    access(1'b1, 1'b1, 3, 2, 4, 2, 2, 3);
    access(1'b0, 1'b1, 1, 1, 2, 1, 1, 1);
    for (int n = 0; n < 40; n++)
      access(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
             $urandom_range(3, 0), $urandom_range(3, 0),
             $urandom_range(4, 1), $urandom_range(2, 0),
             $urandom_range(3, 0), $urandom_range(2, 0));
    nxt();
    rst = 1; mst_req = 1;
    nxt(); settle();
    chk("R1 reset overrides request", cpu_hold_req, 1'b0);
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule